// File: doc/BRIEF.md
# Serial diamond-square heightmap generator

This block builds a square fractal heightmap of side 2^N+1 points, 8 bits per point. A start pulse loads four corner heights. One arithmetic unit then fills the remaining points one at a time. At each half-step h, a diamond pass sets the centre of every filled square. A square pass then sets the centre of every diamond. Each new height is the floor average of four existing points plus a masked random byte, and the sum saturates at 255. The random byte is taken from an external stream, and fewer of its bits are used at each finer level. Edges wrap around toroidally. Once the map is complete, a done flag rises and a host reads any point through a one-cycle-latency read port.

Each grid column lives in its own memory bank. Points in different columns can therefore be read in the same cycle, and the four neighbours of a point need only two read phases. The controller is a state machine with these states: IDLE (waiting), CORNER (four cycles, one corner written per cycle), RDA and RDB (the two read phases), WTA and WTB (one-cycle read-latency waits, at the end of which the operands are latched), CALC (the result is written, the random byte is consumed and the position advances) and DONE (the map is complete). The transitions are: IDLE→CORNER on start; CORNER→RDA after the fourth corner; RDA→WTA→RDB→WTB→CALC unconditionally; CALC→RDA when points remain; CALC→DONE after the last square-pass point at h=1; and DONE→CORNER on start.

Top module: `ds_heightmap`

## Requirements
- R1: After reset, done and rnd_take are low.
- R2: A start pulse in IDLE or DONE writes corner_tl to (row 0, col 0), corner_tr to (0, 2^N), corner_bl to (2^N, 0) and corner_br to (2^N, 2^N). These points are never overwritten.
- R3: The diamond pass at half-step h sets every point whose row and column are both odd multiples of h. Its four operands are the diagonal neighbours (r±h, c±h).
- R4: The square pass at half-step h sets every point whose row and column are multiples of h, with exactly one of them an odd multiple. Its operands are (r±h, c) and (r, c±h). An index below 0 has 2^N added, and an index above 2^N has 2^N subtracted.
- R5: h runs from 2^(N-1) down to 1. At each h the diamond pass runs before the square pass, and each pass visits its points row-major (row outer, column ascending). rnd_take is high for exactly one cycle per computed point, in the cycle where rnd_i is consumed for that point, which makes (2^N+1)^2-4 pulses per run. rnd_take is never high in two consecutive cycles.
- R6: The random byte is masked to its low max(8-d, 1) bits, where d = N-1-log2(h).
- R7: The new height is floor(sum of the 4 operands / 4) plus the masked random byte, saturated at 255.
- R8: done rises exactly 4 + 5·((2^N+1)^2-4) clock edges after the edge that samples start. The cycle before done rises is a rnd_take cycle.
- R9: done stays high until start is sampled, and falls in the cycle after that.
- R10: While done is high, rd_q shows the height at (rd_row, rd_col) as presented one clock edge earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new map (accepted in IDLE or DONE) |
| corner_tl | input | 8 | Height of (0,0) |
| corner_tr | input | 8 | Height of (0,2^N) |
| corner_bl | input | 8 | Height of (2^N,0) |
| corner_br | input | 8 | Height of (2^N,2^N) |
| rnd_i | input | 8 | Random stream byte |
| rnd_take | output | 1 | rnd_i is consumed this cycle |
| done | output | 1 | Map complete |
| rd_row | input | N+1 | Read row index |
| rd_col | input | N+1 | Read column index |
| rd_q | output | 8 | Height read one cycle after the address |

## Verification
A wrong position counter, an operand routed to the wrong bank or a broken wrap rule does not show up as a flag. It shows up as wrong heights at specific points, and the error spreads to every later point that uses them as operands. A full readback after every run compares each point against an independent model, so the fault appears within one map. A miscounted pass or state shifts the done edge and changes the number of rnd_take pulses. Both are visible within a single run.

// File: rtl/ds_pkg.sv
package ds_pkg;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CORNER, ST_RDA, ST_WTA, ST_RDB, ST_WTB, ST_CALC, ST_DONE
    } ds_state_e;

    typedef enum logic {PASS_DIAMOND, PASS_SQUARE} ds_pass_e;

    // toroidal index step down, period span
    function automatic logic [15:0] idx_minus(input logic [15:0] a,
                                              input logic [15:0] h,
                                              input logic [15:0] span);
        return (a >= h) ? (a - h) : (a + span - h);
    endfunction

    // toroidal index step up, period span
    function automatic logic [15:0] idx_plus(input logic [15:0] a,
                                             input logic [15:0] h,
                                             input logic [15:0] span);
        return ((a + h) > span) ? (a + h - span) : (a + h);
    endfunction

    // number of random bits kept shrinks with depth, never below one
    function automatic logic [7:0] noise_mask(input logic [3:0] depth);
        logic [3:0] bits;
        bits = (depth >= 4'd7) ? 4'd1 : (4'd8 - depth);
        return 8'((9'd1 << bits) - 9'd1);
    endfunction

    // floor average plus noise, clipped at full scale
    function automatic logic [7:0] blend(input logic [9:0] sum4,
                                         input logic [7:0] noise);
        logic [8:0] t;
        t = {1'b0, sum4[9:2]} + {1'b0, noise};
        return t[8] ? 8'hFF : t[7:0];
    endfunction

endpackage

// File: rtl/ds_bank.sv
module ds_bank #(
    parameter int DEPTH = 17,
    parameter int AW    = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ds_point.sv
module ds_point
    import ds_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cap_a,
    input  logic       cap_b,
    input  logic       is_sq,
    input  logic [7:0] q_mid,
    input  logic [7:0] q_left,
    input  logic [7:0] q_right,
    input  logic [7:0] noise_i,
    input  logic [3:0] depth,
    output logic [7:0] value_o
);
    logic [7:0] op0, op1, op2, op3;
    logic [9:0] sum4;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op0 <= '0;
            op1 <= '0;
            op2 <= '0;
            op3 <= '0;
        end else begin
            if (cap_a) begin
                if (is_sq) begin
                    op0 <= q_mid;
                    op1 <= q_left;
                    op2 <= q_right;
                end else begin
                    op0 <= q_left;
                    op1 <= q_right;
                end
            end
            if (cap_b) begin
                if (is_sq) begin
                    op3 <= q_mid;
                end else begin
                    op2 <= q_left;
                    op3 <= q_right;
                end
            end
        end
    end

    always_comb begin
        sum4    = {2'b0, op0} + {2'b0, op1} + {2'b0, op2} + {2'b0, op3};
        value_o = blend(sum4, noise_i & noise_mask(depth));
    end
endmodule

// File: rtl/ds_seq.sv
module ds_seq
    import ds_pkg::*;
#(
    parameter int N  = 4,
    parameter int W  = N + 1,
    parameter int HW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output ds_state_e     state_o,
    output ds_pass_e      pass_o,
    output logic [W-1:0]  row_o,
    output logic [W-1:0]  col_o,
    output logic [HW-1:0] hl_o,
    output logic [1:0]    corner_o,
    output logic          wr_en,
    output logic          cap_a,
    output logic          cap_b,
    output logic          rnd_take,
    output logic          done
);
    localparam logic [W:0] SPAN = (W+1)'(2**N);

    ds_state_e  nxt;
    logic [W:0] hx, ncol, nrow1, nrow2;
    logic       col_fits, row1_fits, row2_fits, last_pt, kick;

    always_comb begin
        hx        = (W+1)'(1) << hl_o;
        ncol      = {1'b0, col_o} + (hx << 1);
        nrow1     = {1'b0, row_o} + hx;
        nrow2     = {1'b0, row_o} + (hx << 1);
        col_fits  = (ncol <= SPAN);
        row1_fits = (nrow1 <= SPAN);
        row2_fits = (nrow2 <= SPAN);
        last_pt   = (pass_o == PASS_SQUARE) && !col_fits && !row1_fits && (hl_o == '0);
        kick      = start && ((state_o == ST_IDLE) || (state_o == ST_DONE));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_o <= ST_IDLE;
        else        state_o <= nxt;
    end

    // next state
    always_comb begin
        nxt = state_o;
        unique case (state_o)
            ST_IDLE:   if (start) nxt = ST_CORNER;
            ST_CORNER: if (corner_o == 2'd3) nxt = ST_RDA;
            ST_RDA:    nxt = ST_WTA;
            ST_WTA:    nxt = ST_RDB;
            ST_RDB:    nxt = ST_WTB;
            ST_WTB:    nxt = ST_CALC;
            ST_CALC:   nxt = last_pt ? ST_DONE : ST_RDA;
            ST_DONE:   if (start) nxt = ST_CORNER;
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en    = (state_o == ST_CORNER) || (state_o == ST_CALC);
        cap_a    = (state_o == ST_WTA);
        cap_b    = (state_o == ST_WTB);
        rnd_take = (state_o == ST_CALC);
        done     = (state_o == ST_DONE);
    end

    // position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            corner_o <= '0;
            hl_o     <= '0;
            pass_o   <= PASS_DIAMOND;
            row_o    <= '0;
            col_o    <= '0;
        end else if (kick) begin
            corner_o <= '0;
            hl_o     <= HW'(N - 1);
            pass_o   <= PASS_DIAMOND;
            row_o    <= W'(2**(N-1));
            col_o    <= W'(2**(N-1));
        end else if (state_o == ST_CORNER) begin
            corner_o <= corner_o + 2'd1;
        end else if (state_o == ST_CALC) begin
            if (pass_o == PASS_DIAMOND) begin
                if (col_fits) begin
                    col_o <= W'(ncol);
                end else if (row2_fits) begin
                    row_o <= W'(nrow2);
                    col_o <= W'(hx);
                end else begin
                    pass_o <= PASS_SQUARE;
                    row_o  <= '0;
                    col_o  <= W'(hx);
                end
            end else begin
                if (col_fits) begin
                    col_o <= W'(ncol);
                end else if (row1_fits) begin
                    row_o <= W'(nrow1);
                    col_o <= nrow1[hl_o] ? '0 : W'(hx);
                end else if (hl_o != '0) begin
                    hl_o   <= hl_o - 1'b1;
                    pass_o <= PASS_DIAMOND;
                    row_o  <= W'(hx >> 1);
                    col_o  <= W'(hx >> 1);
                end
            end
        end
    end
endmodule

// File: rtl/ds_heightmap.sv
module ds_heightmap
    import ds_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [7:0]   corner_tl,
    input  logic [7:0]   corner_tr,
    input  logic [7:0]   corner_bl,
    input  logic [7:0]   corner_br,
    input  logic [7:0]   rnd_i,
    output logic         rnd_take,
    output logic         done,
    input  logic [N:0]   rd_row,
    input  logic [N:0]   rd_col,
    output logic [7:0]   rd_q
);
    localparam int W    = N + 1;
    localparam int SIDE = 2**N + 1;
    localparam int HW   = (N > 1) ? $clog2(N) : 1;
    localparam logic [15:0]  SPAN16 = 16'(2**N);
    localparam logic [W-1:0] EDGE   = W'(2**N);

    ds_state_e     state;
    ds_pass_e      pass;
    logic [W-1:0]  row, col, up, dn, lf, rt;
    logic [HW-1:0] hl;
    logic [1:0]    corner;
    logic          wr_en, cap_a, cap_b;
    logic [15:0]   h16;
    logic [3:0]    depth;
    logic [7:0]    value;

    logic [W-1:0]  bank_ra [SIDE];
    logic [7:0]    bank_q  [SIDE];
    logic [SIDE-1:0] bank_we;
    logic [W-1:0]  wr_row, wr_col;
    logic [7:0]    wr_data;
    logic [7:0]    q_mid, q_left, q_right;
    logic [W-1:0]  rd_col_q;
    logic          rd_phase, phase_b;

    ds_seq #(.N(N), .W(W), .HW(HW)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .state_o(state), .pass_o(pass), .row_o(row), .col_o(col),
        .hl_o(hl), .corner_o(corner), .wr_en(wr_en),
        .cap_a(cap_a), .cap_b(cap_b), .rnd_take(rnd_take), .done(done)
    );

    // neighbour indices, wrapping on a period of 2^N
    always_comb begin
        h16   = 16'(1) << hl;
        up    = W'(idx_minus(16'(row), h16, SPAN16));
        dn    = W'(idx_plus (16'(row), h16, SPAN16));
        lf    = W'(idx_minus(16'(col), h16, SPAN16));
        rt    = W'(idx_plus (16'(col), h16, SPAN16));
        depth = 4'(N - 1) - 4'(hl);
        rd_phase = (state == ST_RDA) || (state == ST_RDB);
        phase_b  = (state == ST_RDB);
    end

    // per-bank read address routing
    always_comb begin
        for (int k = 0; k < SIDE; k++) begin
            bank_ra[k] = rd_row;
            if (rd_phase) begin
                if (pass == PASS_DIAMOND) begin
                    if (int'(lf) == k || int'(rt) == k)
                        bank_ra[k] = phase_b ? dn : up;
                end else begin
                    if (int'(col) == k)
                        bank_ra[k] = phase_b ? dn : up;
                    if (int'(lf) == k || int'(rt) == k)
                        bank_ra[k] = row;
                end
            end
        end
    end

    // column selection of bank outputs
    always_comb begin
        q_mid   = '0;
        q_left  = '0;
        q_right = '0;
        rd_q    = '0;
        for (int k = 0; k < SIDE; k++) begin
            if (int'(col) == k)      q_mid   = bank_q[k];
            if (int'(lf) == k)       q_left  = bank_q[k];
            if (int'(rt) == k)       q_right = bank_q[k];
            if (int'(rd_col_q) == k) rd_q    = bank_q[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_col_q <= '0;
        else        rd_col_q <= rd_col;
    end

    // write path: corners first, then computed points
    always_comb begin
        wr_row  = row;
        wr_col  = col;
        wr_data = value;
        if (state == ST_CORNER) begin
            unique case (corner)
                2'd0: begin wr_row = '0;   wr_col = '0;   wr_data = corner_tl; end
                2'd1: begin wr_row = '0;   wr_col = EDGE; wr_data = corner_tr; end
                2'd2: begin wr_row = EDGE; wr_col = '0;   wr_data = corner_bl; end
                default: begin wr_row = EDGE; wr_col = EDGE; wr_data = corner_br; end
            endcase
        end
        for (int k = 0; k < SIDE; k++)
            bank_we[k] = wr_en && (int'(wr_col) == k);
    end

    ds_point u_point (
        .clk(clk), .rst_n(rst_n), .cap_a(cap_a), .cap_b(cap_b),
        .is_sq(pass == PASS_SQUARE), .q_mid(q_mid), .q_left(q_left),
        .q_right(q_right), .noise_i(rnd_i), .depth(depth), .value_o(value)
    );

    for (genvar g = 0; g < SIDE; g++) begin : g_col
        ds_bank #(.DEPTH(SIDE), .AW(W)) u_bank (
            .clk(clk), .we(bank_we[g]), .waddr(wr_row), .wdata(wr_data),
            .raddr(bank_ra[g]), .rdata(bank_q[g])
        );
    end
endmodule

// File: rtl/ds_heightmap_chk.sv
module ds_heightmap_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic done,
    input logic rnd_take
);
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done); // R9
    AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done); // R9
    AST_DONE_AFTER_POINT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(rnd_take)); // R8
    AST_TAKE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_take |=> !rnd_take); // R5
    AST_TAKE_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_take |-> !done); // R5
endmodule

bind ds_heightmap ds_heightmap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .rnd_take(rnd_take)
);

// File: tb/sim_ds_heightmap.sv
module sim_ds_heightmap;
    localparam int N    = 4;
    localparam int SPAN = 2**N;
    localparam int SIDE = SPAN + 1;
    localparam int NPTS = SIDE*SIDE - 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] corner_tl = '0, corner_tr = '0, corner_bl = '0, corner_br = '0;
    logic [7:0] rnd_i = '0;
    logic rnd_take, done;
    logic [N:0] rd_row = '0, rd_col = '0;
    logic [7:0] rd_q;

    int checks = 0;
    int fails  = 0;
    int rv [NPTS];
    int m  [SIDE][SIDE];

    always #10 clk = ~clk;

    ds_heightmap #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .corner_tl(corner_tl), .corner_tr(corner_tr),
        .corner_bl(corner_bl), .corner_br(corner_br),
        .rnd_i(rnd_i), .rnd_take(rnd_take), .done(done),
        .rd_row(rd_row), .rd_col(rd_col), .rd_q(rd_q)
    );

    task automatic check(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    function automatic int wsub(input int a, input int h);
        return (a >= h) ? a - h : a + SPAN - h;
    endfunction
    function automatic int wadd(input int a, input int h);
        return (a + h > SPAN) ? a + h - SPAN : a + h;
    endfunction

    // independent model: R3, R4, R5, R6, R7
    task automatic build_ref(input int tl, input int tr, input int bl, input int br);
        int p = 0;
        m[0][0] = tl; m[0][SPAN] = tr; m[SPAN][0] = bl; m[SPAN][SPAN] = br;
        for (int hl = N-1; hl >= 0; hl--) begin
            int h = 1 << hl;
            int d = N - 1 - hl;
            int bits = (d >= 7) ? 1 : 8 - d;
            int mk = (1 << bits) - 1;
            for (int r = h; r <= SPAN; r += 2*h)
                for (int c = h; c <= SPAN; c += 2*h) begin
                    int s = m[r-h][c-h] + m[r+h][c-h] + m[r-h][c+h] + m[r+h][c+h];
                    int v = s/4 + (rv[p] & mk);
                    p++;
                    m[r][c] = (v > 255) ? 255 : v;
                end
            for (int r = 0; r <= SPAN; r += h) begin
                int cs = ((r/h) % 2 == 1) ? 0 : h;
                for (int c = cs; c <= SPAN; c += 2*h) begin
                    int s = m[wsub(r,h)][c] + m[wadd(r,h)][c] + m[r][wsub(c,h)] + m[r][wadd(c,h)];
                    int v = s/4 + (rv[p] & mk);
                    p++;
                    m[r][c] = (v > 255) ? 255 : v;
                end
            end
        end
    endtask

    function automatic string pos_tag(input int r, input int c);
        int t = r | c;
        int h = t & (~t + 1);
        if ((r == 0 || r == SPAN) && (c == 0 || c == SPAN)) return "R2,R10";
        if (((r/h) % 2 == 1) && ((c/h) % 2 == 1)) return "R3,R6";
        return "R4,R6";
    endfunction

    task automatic run_case(input int tl, input int tr, input int bl, input int br,
                            input string runtag);
        int cnt = 0;
        int takes = 0;
        int ptr = 0;
        bit take_prev = 0;
        build_ref(tl, tr, bl, br);
        @(negedge clk);
        corner_tl = 8'(tl); corner_tr = 8'(tr); corner_bl = 8'(bl); corner_br = 8'(br);
        rnd_i = 8'(rv[0]);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check("R9", "done after start", int'(done), 0);
        forever begin
            if (take_prev) begin
                ptr++;
                rnd_i = (ptr < NPTS) ? 8'(rv[ptr]) : 8'h00;
            end
            take_prev = rnd_take;
            if (rnd_take) takes++;
            if (done) break;
            if (cnt > 20000) begin
                check("R8", "watchdog expired", cnt, 4 + 5*NPTS);
                break;
            end
            @(posedge clk);
            cnt++;
            @(negedge clk);
        end
        check("R8", "cycles to done", cnt, 4 + 5*NPTS);
        check("R5", "rnd_take pulses", takes, NPTS);
        for (int r = 0; r <= SPAN; r++)
            for (int c = 0; c <= SPAN; c++) begin
                rd_row = (N+1)'(r);
                rd_col = (N+1)'(c);
                @(posedge clk);
                @(negedge clk);
                check((runtag != "") ? runtag : pos_tag(r, c),
                      $sformatf("point (%0d,%0d)", r, c), int'(rd_q), m[r][c]);
            end
        check("R9", "done held", int'(done), 1);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        check("R1", "done in reset", int'(done), 0);
        check("R1", "rnd_take in reset", int'(rnd_take), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "done after reset", int'(done), 0);
        check("R1", "rnd_take after reset", int'(rnd_take), 0);

        // all full scale: saturation everywhere
        for (int i = 0; i < NPTS; i++) rv[i] = 255;
        run_case(255, 255, 255, 255, "R7");

        // all zero: floor averages of zero
        for (int i = 0; i < NPTS; i++) rv[i] = 0;
        run_case(0, 0, 0, 0, "R7");

        // distinct corners with no noise exercise wrap and averaging alone
        run_case(240, 10, 130, 60, "");

        // constrained random runs
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < NPTS; i++) rv[i] = int'($urandom_range(0, 255));
            run_case(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                     int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), "");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #3000000;
        fails++;
        $display("FAIL R8 global watchdog got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule